// File: doc/BRIEF.md
# Barrier gate motor controller

This block sequences a motorised barrier arm through closed, opening, open and closing. An operator gives two pushbutton requests, one to raise the arm and one to lower it. The mechanism gives two end-of-travel switches, one for fully raised and one for fully lowered. The block drives two motor-direction lines and two indicator lamps.

All four inputs are asynchronous to the clock. Each one passes through a two-flop synchroniser before the control logic sees it. The controller is a Moore machine with four states held in two register bits. Each state has a fixed code: 00 closed, 01 opening, 10 open, 11 closing. Each state turns on exactly one of the four outputs. A moving state ends only when the matching end-of-travel switch reports arrival. The clock is expected to be slow, in the hertz to kilohertz range.

Top module: `gate_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in the closed state. While the reset is high, and after it is released with every input low, the outputs {motor_open_o, motor_close_o, ind_open_o, ind_closed_o} read 0001.
- R2: In the closed state, a high `open_req_i` moves the controller to opening, where the outputs read 1000. Without it the closed state holds, and `close_req_i`, `lim_open_i` and `lim_closed_i` have no effect.
- R3: In the opening state the outputs read 1000. The state holds while `lim_open_i` is low, even with `close_req_i` high. It moves to open when `lim_open_i` is high.
- R4: In the open state the outputs read 0010. The state holds without `close_req_i`, and `open_req_i` has no effect there.
- R5: In the open state, a high `close_req_i` moves the controller to closing, where the outputs read 0100.
- R6: In the closing state the outputs read 0100. The state holds while `lim_closed_i` is low, even with `open_req_i` high. It returns to closed when `lim_closed_i` is high.
- R7: `motor_open_o` and `motor_close_o` are never high in the same cycle, and exactly one of the four outputs is high in every cycle after reset.
- R8: An input change is sampled by the first rising edge after it is applied. It moves the state, and so the outputs, on the third rising edge. The outputs keep their old values after the first and second edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| open_req_i | input | 1 | Operator request to raise the arm (asynchronous) |
| close_req_i | input | 1 | Operator request to lower the arm (asynchronous) |
| lim_open_i | input | 1 | End-of-travel switch, arm fully raised (asynchronous) |
| lim_closed_i | input | 1 | End-of-travel switch, arm fully lowered (asynchronous) |
| motor_open_o | output | 1 | Drive the motor in the raising direction |
| motor_close_o | output | 1 | Drive the motor in the lowering direction |
| ind_open_o | output | 1 | Lamp: arm fully raised |
| ind_closed_o | output | 1 | Lamp: arm fully lowered |

## Verification
Inputs are applied away from the clock edge. An input change first affects the outputs three rising edges later: two edges for the synchroniser and one for the state register. The driver queues the old output pattern for the two sample points after the change and the new pattern from the third point on. The monitor compares each queued item at the falling edge of the cycle it is due, so a design that responds one cycle early or late fails. A reset takes effect on the next edge, so the bench checks it one cycle after raising it, outside the queue.

// File: rtl/gate_pkg.sv
package gate_pkg;

    // State codes: the output decode depends on these values.
    typedef enum logic [1:0] {
        ST_SHUT     = 2'b00,
        ST_RISING   = 2'b01,
        ST_UP       = 2'b10,
        ST_LOWERING = 2'b11
    } gate_state_e;

    typedef struct packed {
        logic open_req;
        logic close_req;
        logic at_open;
        logic at_shut;
    } gate_in_t;

    typedef struct packed {
        logic drive_up;
        logic drive_down;
        logic lamp_up;
        logic lamp_shut;
    } gate_out_t;

    typedef struct packed {
        gate_state_e state;
    } fsm_regs_t;

    localparam int unsigned GATE_IN_W  = $bits(gate_in_t);
    localparam int unsigned GATE_OUT_W = $bits(gate_out_t);

endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stage_d;
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    assign stage_d[0] = async_i;

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_chain
            assign stage_d[g] = stage_q[g-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
    import gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  gate_in_t    in_i,
    output gate_state_e state_o
);
    fsm_regs_t r_d;
    fsm_regs_t r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_SHUT: begin
                if (in_i.open_req) r_d.state = ST_RISING;
            end
            ST_RISING: begin
                if (in_i.at_open) r_d.state = ST_UP;
            end
            ST_UP: begin
                if (in_i.close_req) r_d.state = ST_LOWERING;
            end
            ST_LOWERING: begin
                if (in_i.at_shut) r_d.state = ST_SHUT;
            end
            default: r_d.state = ST_SHUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_SHUT;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;

endmodule

// File: rtl/gate_outdec.sv
module gate_outdec
    import gate_pkg::*;
(
    input  gate_state_e state_i,
    output gate_out_t   out_o
);
    always_comb begin
        out_o = '0;
        unique case (state_i)
            ST_SHUT:     out_o.lamp_shut  = 1'b1;
            ST_RISING:   out_o.drive_up   = 1'b1;
            ST_UP:       out_o.lamp_up    = 1'b1;
            ST_LOWERING: out_o.drive_down = 1'b1;
            default:     out_o.lamp_shut  = 1'b1;
        endcase
    end

endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
    import gate_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic open_req_i,
    input  logic close_req_i,
    input  logic lim_open_i,
    input  logic lim_closed_i,
    output logic motor_open_o,
    output logic motor_close_o,
    output logic ind_open_o,
    output logic ind_closed_o
);
    logic [GATE_IN_W-1:0] raw_in;
    logic [GATE_IN_W-1:0] sync_in;
    gate_in_t             clean_in;
    gate_state_e          state;
    gate_out_t            outs;

    assign raw_in = {open_req_i, close_req_i, lim_open_i, lim_closed_i};

    gate_sync #(
        .WIDTH  (GATE_IN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    assign clean_in = gate_in_t'(sync_in);

    gate_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .in_i    (clean_in),
        .state_o (state)
    );

    gate_outdec u_dec (
        .state_i (state),
        .out_o   (outs)
    );

    assign motor_open_o  = outs.drive_up;
    assign motor_close_o = outs.drive_down;
    assign ind_open_o    = outs.lamp_up;
    assign ind_closed_o  = outs.lamp_shut;

endmodule

// File: rtl/gate_ctrl_chk.sv
module gate_ctrl_chk #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst,
    input logic open_req_i,
    input logic close_req_i,
    input logic lim_open_i,
    input logic lim_closed_i,
    input logic motor_open_o,
    input logic motor_close_o,
    input logic ind_open_o,
    input logic ind_closed_o
);
    // R1: the cycle after a reset edge shows the closed pattern
    p_reset_closed_r1: assert property (@(posedge clk)
        rst |=> (ind_closed_o && !ind_open_o && !motor_open_o && !motor_close_o));

    // R2: closed may only stay closed or start opening
    p_from_closed_r2: assert property (@(posedge clk) disable iff (rst)
        ind_closed_o |=> (ind_closed_o || motor_open_o));

    // R3: opening may only continue or reach open
    p_from_opening_r3: assert property (@(posedge clk) disable iff (rst)
        motor_open_o |=> (motor_open_o || ind_open_o));

    // R4, R5: open may only stay open or start closing
    p_from_open_r5: assert property (@(posedge clk) disable iff (rst)
        ind_open_o |=> (ind_open_o || motor_close_o));

    // R6: closing may only continue or reach closed
    p_from_closing_r6: assert property (@(posedge clk) disable iff (rst)
        motor_close_o |=> (motor_close_o || ind_closed_o));

    // R7: never drive both directions; exactly one output active
    p_no_both_motors_r7: assert property (@(posedge clk) disable iff (rst)
        !(motor_open_o && motor_close_o));

    p_one_active_r7: assert property (@(posedge clk) disable iff (rst)
        $countones({motor_open_o, motor_close_o, ind_open_o, ind_closed_o}) == 1);

    // R8: each move is caused by the input seen three edges earlier (two-flop chain)
    generate
        if (SYNC_STAGES == 2) begin : g_lat
            p_open_latency_r8: assert property (@(posedge clk) disable iff (rst)
                $rose(motor_open_o) |-> $past(open_req_i, 3));

            p_up_latency_r8: assert property (@(posedge clk) disable iff (rst)
                $rose(ind_open_o) |-> $past(lim_open_i, 3));

            p_close_latency_r8: assert property (@(posedge clk) disable iff (rst)
                $rose(motor_close_o) |-> $past(close_req_i, 3));
        end
    endgenerate

endmodule

bind gate_ctrl gate_ctrl_chk #(
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .open_req_i    (open_req_i),
    .close_req_i   (close_req_i),
    .lim_open_i    (lim_open_i),
    .lim_closed_i  (lim_closed_i),
    .motor_open_o  (motor_open_o),
    .motor_close_o (motor_close_o),
    .ind_open_o    (ind_open_o),
    .ind_closed_o  (ind_closed_o)
);

// File: tb/tb_gate_ctrl.sv
module tb_gate_ctrl;

    localparam time CLK_HALF = 2.5ns;
    localparam int  WATCHDOG = 200000;

    // Output patterns {motor_open, motor_close, ind_open, ind_closed}
    localparam logic [3:0] E_CLOSED  = 4'b0001;
    localparam logic [3:0] E_OPENING = 4'b1000;
    localparam logic [3:0] E_OPEN    = 4'b0010;
    localparam logic [3:0] E_CLOSING = 4'b0100;

    // Input patterns {open_req, close_req, lim_open, lim_closed}
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic open_req = 1'b0, close_req = 1'b0, lim_open = 1'b0, lim_closed = 1'b0;
    logic mo, mc, go, gc;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int         due;
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t      sb[$];
    item_t      it;
    logic [3:0] cur_exp = E_CLOSED;

    always #(CLK_HALF) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gate_ctrl dut (
        .clk           (clk),
        .rst           (rst),
        .open_req_i    (open_req),
        .close_req_i   (close_req),
        .lim_open_i    (lim_open),
        .lim_closed_i  (lim_closed),
        .motor_open_o  (mo),
        .motor_close_o (mc),
        .ind_open_o    (go),
        .ind_closed_o  (gc)
    );

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%b expected=%b", tag, cyc, act, exp);
        end
        total++;
        if (mo === 1'b1 && mc === 1'b1) begin
            bad++;
            $display("FAIL R7 cyc=%0d actual=both_motors expected=exclusive", cyc);
        end
    endtask

    // Monitor: compare queued expectations at the falling edge they are due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            it = sb.pop_front();
            check({mo, mc, go, gc}, it.exp, it.tag);
        end
    end

    // Driver: apply inputs at a falling edge and queue the expected outputs
    task automatic drive(input logic [3:0] ins, input logic [3:0] exp_new,
                         input string tag, input int hold);
        int c;
        {open_req, close_req, lim_open, lim_closed} = ins;
        c = cyc;
        sb.push_back('{c + 1, cur_exp, {tag, "/R8 old@1"}});
        sb.push_back('{c + 2, cur_exp, {tag, "/R8 old@2"}});
        for (int k = 3; k <= hold; k++) begin
            sb.push_back('{c + k, exp_new, tag});
        end
        cur_exp = exp_new;
        repeat (hold) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({mo, mc, go, gc}, E_CLOSED, "R1 reset held");
        rst = 1'b0;
        @(negedge clk);
        check({mo, mc, go, gc}, E_CLOSED, "R1 after release");

        drive(4'b0001, E_CLOSED,  "R2 idle closed",             4);
        drive(4'b0101, E_CLOSED,  "R2 close_req ignored",       4);
        drive(4'b0010, E_CLOSED,  "R2 lim_open ignored",        4);
        drive(4'b1001, E_OPENING, "R2 open request",            4);
        drive(4'b0000, E_OPENING, "R3 hold while moving",       4);
        drive(4'b0100, E_OPENING, "R3 close_req while opening", 4);
        drive(4'b0010, E_OPEN,    "R3 open limit reached",      4);
        drive(4'b1010, E_OPEN,    "R4 open_req ignored",        4);
        drive(4'b0010, E_OPEN,    "R4 hold open",               5);
        drive(4'b0110, E_CLOSING, "R5 close request",           4);
        drive(4'b0000, E_CLOSING, "R6 hold while moving",       4);
        drive(4'b1000, E_CLOSING, "R6 open_req while closing",  4);
        drive(4'b0001, E_CLOSED,  "R6 closed limit reached",    4);
        drive(4'b1001, E_OPENING, "R2 second open",             3);
        drive(4'b0000, E_OPENING, "R3 second travel",           4);
        @(negedge clk);

        // Reset in mid travel: takes effect on the next edge
        rst = 1'b1;
        @(negedge clk);
        check({mo, mc, go, gc}, E_CLOSED, "R1 reset mid travel");
        rst = 1'b0;
        cur_exp = E_CLOSED;
        @(negedge clk);
        check({mo, mc, go, gc}, E_CLOSED, "R1 stays closed");

        drive(4'b0001, E_CLOSED, "R2 idle after reset", 4);
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule